// File: doc/BRIEF.md
# Supply and Manual Reset Generator

This block drives the processor reset of a supervisory controller. It watches two fault sources, a supply-low flag that an external threshold comparator delivers already synchronous to `clk` and an asynchronous active-low manual reset request, and holds the processor in reset while either is present. Once both have gone away it keeps reset asserted for a fixed number of clock cycles, `STRETCH_CYCLES`, so that supply and processor can settle. The same stretch also debounces a mechanical reset switch: any low level seen on the manual input during the stretch starts the count again.

The reset is driven in both polarities from separate registers, and a reset-active flag is exported for a companion watchdog so that it can clear its timer while reset is active. A watchdog timeout resets the processor only if the system routes the watchdog output into `man_rst_n`; this block has no watchdog input of its own. The power-on clear `pwron_n` puts the block in the state it would have right after a supply recovery: reset asserted and a full stretch loaded.

Control is a three-state machine. HOLD means a fault is present. STRETCH means the count is running. RUN means reset is released. The transitions are: FAULT_SEEN (any state to HOLD, whenever a fault is sampled), QUIET (HOLD to STRETCH, on the first clean sample, with the counter loaded to `STRETCH_CYCLES-1`), EXPIRE (STRETCH to RUN, on a clean sample with the counter at zero) and COUNT (STRETCH to STRETCH, decrementing). Power-on enters STRETCH with the counter loaded.

Top module: `supply_reset_gen`

## Requirements
- R1: While `pwron_n` is low, `rst_out` is 1. After `pwron_n` rises, `rst_out` stays 1 until the `STRETCH_CYCLES`-th rising clock edge, and it is 0 after that edge.
- R2: A rising edge that samples `supply_low` = 1 sets `rst_out` to 1 after that edge. `rst_out` stays 1 for as long as `supply_low` is sampled high.
- R3: `man_rst_n` passes through a two-flop synchronizer. A low level sampled at edge k sets `rst_out` to 1 after edge k+2, and `rst_out` stays 1 while the low persists.
- R4: Take e0 as the first edge at which neither fault is seen, after an edge that saw a fault. `rst_out` stays 1 through edge e0+`STRETCH_CYCLES`-1 and falls after edge e0+`STRETCH_CYCLES`, as long as no fault appears in between.
- R5: Release after a manual reset follows the same stretch as R4, counted from the first edge at which the synchronized manual request is seen high.
- R6: A fault seen during a running stretch restarts the full stretch, counted from the edge at which that fault clears again.
- R7: Low glitches on `man_rst_n`, a single cycle wide included, cannot end reset early. Each one restarts the stretch.
- R8: `rst_out_n` is always the complement of `rst_out`.
- R9: `rst_busy` is 1 exactly when `rst_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| pwron_n | input | 1 | Asynchronous power-on clear, active low |
| supply_low | input | 1 | Synchronous supply-below-threshold flag, active high |
| man_rst_n | input | 1 | Asynchronous manual reset request, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| rst_busy | output | 1 | Reset-active flag for the companion watchdog |

## Verification
The bench goes after the exact release edge, both after power-on and after each kind of fault. A counter loaded one value off, or loaded on the wrong edge, would release reset one cycle early or one cycle late. It also injects a second supply dip and one-cycle manual glitches in the middle of a stretch: a design that only resumed its count, or ignored a fault once it had left HOLD, would release too early. Random traffic on both sources checks that the two polarities never disagree, and that the three-cycle latency of the synchronized manual input is neither shortened nor lengthened.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    // Control states of the reset generator
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,   // a fault source is active
        ST_STRETCH = 2'd1,   // faults gone, stretch count running
        ST_RUN     = 2'd2    // reset released
    } rg_state_t;

    // Counter width able to hold values up to n-1 (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain_q[i] <= RESET_VAL;
                    else         chain_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain_q[i] <= RESET_VAL;
                    else         chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[LAST];
endmodule

// File: rtl/rg_stretch_timer.sv
module rg_stretch_timer
    import rstgen_pkg::*;
#(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = cnt_width(CYCLES);
    localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Power-on leaves a full stretch loaded
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= TOP;
        end else if (load) begin
            cnt_q <= TOP;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rg_ctrl_fsm.sv
module rg_ctrl_fsm
    import rstgen_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic fault,
    input  logic done,
    output logic load,
    output logic tick,
    output logic rst_hi,
    output logic rst_lo,
    output logic busy
);
    rg_state_t state_q;
    rg_state_t state_d;
    logic      rst_hi_q;
    logic      rst_lo_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (fault) begin
            state_d = ST_HOLD;                  // FAULT_SEEN
        end else begin
            unique case (state_q)
                ST_HOLD:    state_d = ST_STRETCH;  // QUIET
                ST_STRETCH: state_d = done ? ST_RUN : ST_STRETCH; // EXPIRE / COUNT
                ST_RUN:     state_d = ST_RUN;
                default:    state_d = ST_HOLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_STRETCH;
        else         state_q <= state_d;
    end

    // Output registers, one per polarity, follow the next state
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rst_hi_q <= 1'b1;
            rst_lo_q <= 1'b0;
        end else begin
            rst_hi_q <= (state_d != ST_RUN);
            rst_lo_q <= (state_d == ST_RUN);
        end
    end

    // Counter held at full length while faulted or on the QUIET transition
    assign load   = fault || (state_q == ST_HOLD);
    assign tick   = (state_q == ST_STRETCH);
    assign rst_hi = rst_hi_q;
    assign rst_lo = rst_lo_q;
    assign busy   = (state_q != ST_RUN);
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
    import rstgen_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 50_000_000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic pwron_n,
    input  logic supply_low,
    input  logic man_rst_n,
    output logic rst_out_n,
    output logic rst_out,
    output logic rst_busy
);
    logic mr_n_s;
    logic mr_low_s;
    logic fault;
    logic load;
    logic tick;
    logic done;

    rg_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk    (clk),
        .arst_n (pwron_n),
        .d      (man_rst_n),
        .q      (mr_n_s)
    );

    assign mr_low_s = !mr_n_s;
    assign fault    = supply_low || mr_low_s;

    rg_stretch_timer #(
        .CYCLES (STRETCH_CYCLES)
    ) u_timer (
        .clk    (clk),
        .arst_n (pwron_n),
        .load   (load),
        .tick   (tick),
        .done   (done)
    );

    rg_ctrl_fsm u_fsm (
        .clk    (clk),
        .arst_n (pwron_n),
        .fault  (fault),
        .done   (done),
        .load   (load),
        .tick   (tick),
        .rst_hi (rst_out),
        .rst_lo (rst_out_n),
        .busy   (rst_busy)
    );
endmodule

// File: rtl/supply_reset_gen_chk.sv
module supply_reset_gen_chk #(
    parameter int unsigned STRETCH_CYCLES = 16
) (
    input logic clk,
    input logic pwron_n,
    input logic supply_low,
    input logic man_rst_n,
    input logic mr_low_s,
    input logic rst_out_n,
    input logic rst_out,
    input logic rst_busy
);
    localparam int unsigned QW = $clog2(STRETCH_CYCLES + 2);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH_CYCLES + 1);

    // Clean edges since the last sampled fault, saturating
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk or negedge pwron_n) begin
        if (!pwron_n)                      quiet_q <= QW'(1);
        else if (supply_low || mr_low_s)   quiet_q <= '0;
        else if (quiet_q != QMAX)          quiet_q <= quiet_q + 1'b1;
    end

    assert_polarity_R8: assert property (@(posedge clk) disable iff (!pwron_n)
        rst_out == !rst_out_n);

    assert_busy_match_R9: assert property (@(posedge clk) disable iff (!pwron_n)
        rst_busy == rst_out);

    assert_supply_forces_R2: assert property (@(posedge clk) disable iff (!pwron_n)
        supply_low |=> rst_out);

    assert_manual_latency_R3: assert property (@(posedge clk) disable iff (!pwron_n)
        !man_rst_n |=> ##2 rst_out);

    // R4, R5, R6 and R7: never released inside a stretch window
    assert_no_early_release_R4: assert property (@(posedge clk) disable iff (!pwron_n)
        (quiet_q != QMAX) |-> rst_out);

    assert_release_on_time_R6: assert property (@(posedge clk) disable iff (!pwron_n)
        $fell(rst_out) |-> (quiet_q == QMAX));

    assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!pwron_n)
        $rose(rst_out) |-> ($past(supply_low) || $past(mr_low_s)));
endmodule

bind supply_reset_gen supply_reset_gen_chk #(
    .STRETCH_CYCLES (STRETCH_CYCLES)
) u_chk (
    .clk        (clk),
    .pwron_n    (pwron_n),
    .supply_low (supply_low),
    .man_rst_n  (man_rst_n),
    .mr_low_s   (mr_low_s),
    .rst_out_n  (rst_out_n),
    .rst_out    (rst_out),
    .rst_busy   (rst_busy)
);

// File: tb/supply_reset_gen_test.sv
`timescale 1ns/1ps
module supply_reset_gen_test;
    localparam int unsigned N = 16;

    logic clk = 1'b0;
    logic pwron_n = 1'b0;
    logic supply_low = 1'b0;
    logic man_rst_n = 1'b1;
    logic rst_out_n;
    logic rst_out;
    logic rst_busy;

    int n_checks = 0;
    int n_fails = 0;
    string cur_tag = "R1";
    bit done_flag = 1'b0;

    // Reference: clean edges since last fault, manual pipe of two flops
    int unsigned quiet = 1;
    logic [1:0] pipe = 2'b11;

    always #2 clk = ~clk;

    supply_reset_gen #(
        .STRETCH_CYCLES (N),
        .SYNC_STAGES    (2)
    ) uut (
        .clk        (clk),
        .pwron_n    (pwron_n),
        .supply_low (supply_low),
        .man_rst_n  (man_rst_n),
        .rst_out_n  (rst_out_n),
        .rst_out    (rst_out),
        .rst_busy   (rst_busy)
    );

    function automatic bit exp_reset(input int unsigned q);
        return (q <= N);
    endfunction

    always @(posedge clk) begin
        if (!pwron_n) begin
            quiet = 1;
            pipe  = 2'b11;
        end else begin
            if (supply_low || !pipe[1]) quiet = 0;
            else if (quiet <= N)        quiet = quiet + 1;
            pipe = {pipe[0], man_rst_n};
        end
    end

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Compare well away from the rising edge
    always @(negedge clk) begin
        #1;
        if (!done_flag) begin
            check(cur_tag, "rst_out", rst_out, exp_reset(quiet));
            check("R8", "rst_out_n", rst_out_n, !exp_reset(quiet));
            check("R9", "rst_busy", rst_busy, exp_reset(quiet));
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state and power-on stretch
        cur_tag = "R1";
        cycles(4);
        pwron_n = 1'b1;
        cycles(N + 4);

        // R2 then R4: supply dip and release
        cur_tag = "R2";
        supply_low = 1'b1;
        cycles(5);
        cur_tag = "R4";
        supply_low = 1'b0;
        cycles(N + 4);

        // R3 then R5: manual request through the synchronizer
        cur_tag = "R3";
        man_rst_n = 1'b0;
        cycles(4);
        cur_tag = "R5";
        man_rst_n = 1'b1;
        cycles(N + 5);

        // R6: second dip in mid-stretch restarts the count
        cur_tag = "R6";
        supply_low = 1'b1;
        cycles(3);
        supply_low = 1'b0;
        cycles(N / 2);
        supply_low = 1'b1;
        cycles(2);
        supply_low = 1'b0;
        cycles(N - 1);
        supply_low = 1'b1;
        cycles(1);
        supply_low = 1'b0;
        cycles(N + 4);

        // R7: bouncing switch and single-cycle glitches
        cur_tag = "R7";
        for (int i = 0; i < 12; i++) begin
            man_rst_n = 1'($urandom_range(0, 1));
            cycles(1);
        end
        man_rst_n = 1'b1;
        cycles(N - 2);
        man_rst_n = 1'b0;
        cycles(1);
        man_rst_n = 1'b1;
        cycles(N + 5);

        // Constrained random mix of both sources
        cur_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 4) supply_low = ~supply_low;
            if ($urandom_range(0, 99) < 3) man_rst_n = ~man_rst_n;
            if (supply_low && $urandom_range(0, 99) < 20) supply_low = 1'b0;
            if (!man_rst_n && $urandom_range(0, 99) < 30) man_rst_n = 1'b1;
            cycles(1);
        end
        supply_low = 1'b0;
        man_rst_n = 1'b1;
        cur_tag = "R4";
        cycles(N + 5);

        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done_flag = 1'b1;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule